// File: doc/BRIEF.md
# Charger Input Protection Sequencer

This block decides when the power pass switch between a charger input and the charging system may conduct. It reads registered comparator flags for four conditions: input present above the undervoltage floor, input above the overvoltage ceiling, battery too high, and die too hot. It also reads an active-low enable and a level request from a separate overcurrent block. From these it drives the switch enable, a fault line that either pulls low or releases, and a one-cycle pulse that tells neighbouring blocks to clear their event counters.

Each fault has its own rule.
- Overvoltage opens the switch at once and closes it again only after a timed quiet period.
- A battery overvoltage has to persist for a deglitch window before it acts. It releases as soon as the flag drops. Its events are counted, and the fifteenth event latches the switch off.
- Overtemperature and the overcurrent request act while they are asserted.

Two global overrides reset everything and release the fault line: losing input power and lifting the enable. All time is counted in ticks from an internal prescaler, so every duration is a parameter.

Top module: `chg_prot_seq`

## Requirements
- R1: While the synchronized input-present flag is low, the switch is off and the fault line is released (`flt_drive`=0), whatever the other inputs do.
- R2: After input present and enable are both good, the switch stays off for a power-good wait of `PG_TICKS` ticks. It then turns on if no fault is active.
- R3: If overvoltage is already asserted when the power-good wait ends, the switch never turns on, and `flt_drive`=1 until the flag clears and the recovery delay completes.
- R4: Overvoltage during operation turns the switch off and sets `flt_drive`=1 within the synchronizer latency, with no deglitch.
- R5: After overvoltage clears, the switch stays off with `flt_drive`=1 for `OVREC_TICKS` ticks and then turns on. A new overvoltage during this wait restarts it.
- R6: Battery overvoltage acts only after persisting for `BATDG_TICKS` ticks, so a shorter pulse leaves the switch on. Once it acts, the switch is off with `flt_drive`=1, and the switch turns on again as soon as the flag clears.
- R7: The `BAT_LIMIT`-th battery overvoltage event (default 15) latches the switch off with `flt_drive`=1 until enable is lifted or input power is lost.
- R8: Overtemperature holds the switch off with `flt_drive`=1 while asserted, and the switch returns when it clears.
- R9: Enable high (`en_n`=1) forces the switch off and releases the fault line. It also clears the battery event count and any lockout.
- R10: The overcurrent request (`ocp_req`, not synchronized) holds the switch off with `flt_drive`=1 on the next cycle while asserted. The switch returns on release without delay.
- R11: `cnt_clr` pulses high for exactly one cycle each time the block enters disable or power-down.
- R12: Overvoltage has priority over the other faults. If overvoltage and overtemperature clear together, the overvoltage recovery delay still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_ok | input | 1 | Input above undervoltage threshold (async) |
| ov | input | 1 | Input above overvoltage threshold (async) |
| bat_ov | input | 1 | Battery above overvoltage threshold (async) |
| hot | input | 1 | Die over temperature (async) |
| en_n | input | 1 | Active-low enable (async) |
| ocp_req | input | 1 | Overcurrent block requests switch off (synchronous) |
| sw_on | output | 1 | Pass switch enable |
| flt_drive | output | 1 | 1 = pull fault line low, 0 = release |
| cnt_clr | output | 1 | One-cycle counter-clear pulse |

## Verification
A corrupted state shows at the ports in one of two ways: the switch conducts while a condition should hold it open, or the fault line disagrees with the switch. For an immediate fault source, either shows within three cycles of the flag. A timer or deglitch counter with a wrong value moves the instant the switch closes by at least one tick, and the bench brackets each window on both sides. A battery event counter that drifts shows up only at the lockout: the switch either stays on after the fifteenth pulse or latches early, so every pulse in the sequence is checked.

// File: rtl/chg_prot_seq.sv
module chg_prot_seq #(
  parameter int TICK_DIV    = 100,
  parameter int PG_TICKS    = 8000,
  parameter int OVREC_TICKS = 8000,
  parameter int BATDG_TICKS = 176,
  parameter int BAT_LIMIT   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok,
  input  logic ov,
  input  logic bat_ov,
  input  logic hot,
  input  logic en_n,
  input  logic ocp_req,
  output logic sw_on,
  output logic flt_drive,
  output logic cnt_clr
);
  localparam int TMAX = (PG_TICKS > OVREC_TICKS) ? PG_TICKS : OVREC_TICKS;
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int TW = $clog2(TMAX + 1);
  localparam int DW = $clog2(BATDG_TICKS + 1);
  localparam int CW = $clog2(BAT_LIMIT + 1);

  typedef enum logic [3:0] {
    S_OFF, S_RST, S_PG, S_RUN, S_OVF, S_OVREC, S_OCP, S_BAT, S_HOT, S_LOCK
  } st_t;

  logic [4:0] sy1, sy2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 5'b10000;
      sy2 <= 5'b10000;
    end else begin
      sy1 <= {en_n, hot, bat_ov, ov, uv_ok};
      sy2 <= sy1;
    end

  logic uv_s, ov_s, bat_s, hot_s, en_n_s;
  assign {en_n_s, hot_s, bat_s, ov_s, uv_s} = sy2;

  logic hold, hold_q;
  assign hold = !uv_s || en_n_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold;
  assign cnt_clr = hold && !hold_q;

  logic [PW-1:0] pre;
  logic tick;
  assign tick = (pre == PW'(TICK_DIV - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;

  st_t state, nxt, rs_nxt;
  logic [TW-1:0] tmr;
  logic [DW-1:0] dg;
  logic [CW-1:0] bat_cnt;
  logic bat_due, cnt_inc;

  assign bat_due = (dg == DW'(BATDG_TICKS)) && (state != S_BAT);

  always_comb begin
    if (ov_s)                         rs_nxt = S_OVF;
    else if (ocp_req)                 rs_nxt = S_OCP;
    else if (state == S_BAT && bat_s) rs_nxt = S_BAT;
    else if (bat_due)                 rs_nxt = (bat_cnt == CW'(BAT_LIMIT - 1)) ? S_LOCK : S_BAT;
    else if (hot_s)                   rs_nxt = S_HOT;
    else                              rs_nxt = S_RUN;
  end

  always_comb begin
    nxt = state;
    if (!uv_s)       nxt = S_OFF;
    else if (en_n_s) nxt = S_RST;
    else
      case (state)
        S_OFF, S_RST: nxt = S_PG;
        S_PG:         nxt = (tmr == TW'(PG_TICKS)) ? rs_nxt : S_PG;
        S_OVF:        nxt = ov_s ? S_OVF : S_OVREC;
        S_OVREC:      nxt = ov_s ? S_OVF : (tmr == TW'(OVREC_TICKS)) ? rs_nxt : S_OVREC;
        S_LOCK:       nxt = S_LOCK;
        default:      nxt = rs_nxt;
      endcase
  end

  assign cnt_inc = (nxt == S_BAT || nxt == S_LOCK) && state != S_BAT && state != S_LOCK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_OFF;
      tmr     <= '0;
      dg      <= '0;
      bat_cnt <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)                     tmr <= '0;
      else if (tick && tmr != TW'(TMAX))    tmr <= tmr + 1'b1;
      if (hold || !bat_s)                   dg <= '0;
      else if (tick && dg != DW'(BATDG_TICKS)) dg <= dg + 1'b1;
      if (hold)         bat_cnt <= '0;
      else if (cnt_inc) bat_cnt <= bat_cnt + 1'b1;
    end

  assign sw_on     = (state == S_RUN);
  assign flt_drive = (state == S_OVF) || (state == S_OVREC) || (state == S_OCP) ||
                     (state == S_BAT) || (state == S_HOT)   || (state == S_LOCK);

  a_r1_powerdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_s |=> (!sw_on && !flt_drive));
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_s && en_n_s) |=> (!sw_on && !flt_drive));
  a_r4_ov_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> !sw_on);
  a_r8_hot_opens: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |=> !sw_on);
  a_r10_ocp_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_req |=> !sw_on);
  a_r7_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK && !hold) |=> (state == S_LOCK));
  a_r11_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);
endmodule

// File: tb/test_chg_prot_seq.sv
module test_chg_prot_seq;
  localparam int CLK_P = 10;
  localparam int DIV = 4, PG = 6, REC = 5, DG = 3;

  logic clk = 0, rst_n = 0;
  logic uv_ok = 0, ov = 0, bat_ov = 0, hot = 0, en_n = 0, ocp_req = 0;
  logic sw_on, flt_drive, cnt_clr;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  chg_prot_seq #(.TICK_DIV(DIV), .PG_TICKS(PG), .OVREC_TICKS(REC), .BATDG_TICKS(DG))
    i_chg_prot_seq (.clk, .rst_n, .uv_ok, .ov, .bat_ov, .hot, .en_n, .ocp_req,
                    .sw_on, .flt_drive, .cnt_clr);

  function automatic logic exp_run_sw(logic o, logic h);
    return !(o || h);
  endfunction

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic exp_sw, logic exp_flt);
    checks++;
    if (sw_on !== exp_sw || flt_drive !== exp_flt) begin
      errors++;
      $display("FAIL %s: sw_on=%b flt_drive=%b expected sw_on=%b flt_drive=%b",
               req, sw_on, flt_drive, exp_sw, exp_flt);
    end
  endtask

  task automatic count_clr(string req, int exp);
    int n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cnt_clr) n++;
    end
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s: cnt_clr pulses=%0d expected %0d", req, n, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen_on;
    void'($urandom(32'd1234));
    w(5);
    rst_n = 1;
    w(4);
    chk("R1 reset/powerdown", 0, 0);
    ov = 1; hot = 1; w(4);
    chk("R1 faults ignored in powerdown", 0, 0);
    ov = 0; hot = 0;

    uv_ok = 1; w(18);
    chk("R2 still in power-good wait", 0, 0);
    w(14);
    chk("R2 on after power-good wait", 1, 0);

    ov = 1; w(4);
    chk("R4 overvoltage immediate", 0, 1);
    ov = 0; w(14);
    chk("R5 still in recovery", 0, 1);
    w(16);
    chk("R5 on after recovery", 1, 0);

    ocp_req = 1; w(2);
    chk("R10 ocp request holds off", 0, 1);
    ocp_req = 0; w(2);
    chk("R10 ocp release", 1, 0);

    hot = 1; w(4);
    chk("R8 overtemp off", 0, 1);
    hot = 0; w(4);
    chk("R8 overtemp clears", 1, 0);

    for (int i = 0; i < 30; i++) begin
      logic o, h;
      o = 1'($urandom_range(0, 1));
      h = 1'($urandom_range(0, 1));
      ocp_req = o; hot = h; w(5);
      chk(o ? "R10 random" : "R8 random", exp_run_sw(o, h), !exp_run_sw(o, h));
    end
    ocp_req = 0; hot = 0; w(5);
    chk("R8 random end", 1, 0);

    bat_ov = 1; w(4); bat_ov = 0; w(6);
    chk("R6 short pulse ignored", 1, 0);
    for (int k = 1; k <= 14; k++) begin
      bat_ov = 1; w(20);
      chk("R6 persisted battery fault", 0, 1);
      bat_ov = 0; w(6);
      chk("R6 battery fault releases", 1, 0);
    end
    bat_ov = 1; w(20); bat_ov = 0; w(6);
    chk("R7 fifteenth fault latches", 0, 1);
    w(40);
    chk("R7 lock persists", 0, 1);

    en_n = 1;
    count_clr("R11 pulse on disable", 1);
    chk("R9 disable releases", 0, 0);
    en_n = 0; w(32);
    chk("R9 lock cleared by enable toggle", 1, 0);

    ov = 1; uv_ok = 0;
    count_clr("R11 pulse on powerdown", 1);
    chk("R1 powerdown with ov", 0, 0);
    uv_ok = 1;
    seen_on = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sw_on) seen_on = 1;
    end
    checks++;
    if (seen_on) begin
      errors++;
      $display("FAIL R3: sw_on seen=1 expected 0");
    end
    chk("R3 fault after power-good wait", 0, 1);
    ov = 0; w(32);
    chk("R3 on after ov clears", 1, 0);

    ov = 1; hot = 1; w(4);
    chk("R12 both faults", 0, 1);
    ov = 0; hot = 0; w(10);
    chk("R12 ov recovery governs", 0, 1);
    w(20);
    chk("R12 on after recovery", 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule